// File: doc/BRIEF.md
# Path Overhead Alarm Monitor

This block watches the path-level overhead of a synchronous optical transport stream one frame at a time. On each frame it receives a summary of the pointer bytes, the signal label byte and the path status byte. From these it keeps four alarm flags: loss of pointer, path alarm indication, signal label mismatch and path remote defect. Each flag is set and released only after the condition has persisted over a given number of consecutive frames. It also adds the far-end error count carried in the status byte into a saturating accumulator. The control side reads this accumulator and clears it.

An upstream pointer stage classifies the pointer bytes before they reach this block. The block only counts runs of those classes and compares successive pointer values. It does not locate the payload or compute any parity over it.

Top module: `path_alarm_mon`

## Requirements
- R1: After reset all four flags and the error count are zero. Flags and count change only on a clock edge where `frame_stb` is high, or where `cnt_clr` is high for the count. The flag decided by a frame is visible right after that edge.
- R2: `ptr_class` encodes 0 = invalid pointer, 1 = valid pointer with normal NDF, 2 = valid pointer with NDF enabled, 3 = both pointer bytes all ones. `lop` is set by the 8th consecutive frame of class 0, or by the 8th consecutive frame of class 2.
- R3: `lop` clears on the 3rd consecutive class-1 frame carrying the same `ptr_value`. A class-1 value that differs from the previous class-1 value restarts this run at one. Any other class restarts it at zero.
- R4: `path_ais` is set by the 3rd consecutive frame of class 3.
- R5: `path_ais` clears through the same three-identical-normal-pointer run as in R3. It also clears at once on a single class-2 frame.
- R6: `c2_mismatch` is set after 5 consecutive frames whose `c2_byte` differs from 8'h13. It clears after 5 consecutive frames equal to 8'h13.
- R7: `path_rdi` is set after 10 consecutive frames with `g1_byte[3]` high (bit 5 when bit 1 is the MSB). It clears after 10 consecutive frames with that bit low.
- R8: Each frame adds the weight of `g1_byte[7:4]` to `febe_count`. Values 0 to 8 add their own value and values 9 to 15 add zero.
- R9: `febe_count` stops at 65535 and never wraps.
- R10: `cnt_clr` zeroes `febe_count` on the next edge. It wins over a frame arriving in the same cycle, and that frame's errors are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | One-cycle strobe marking a frame's overhead inputs as valid |
| ptr_class | input | 2 | Pointer classification (encoding in R2) |
| ptr_value | input | 10 | Pointer offset value |
| c2_byte | input | 8 | Signal label byte |
| g1_byte | input | 8 | Path status byte |
| cnt_clr | input | 1 | Clear request for the error count |
| lop | output | 1 | Loss of pointer |
| path_ais | output | 1 | Path alarm indication |
| c2_mismatch | output | 1 | Signal label mismatch |
| path_rdi | output | 1 | Path remote defect |
| febe_count | output | 16 | Saturating far-end error count |

## Verification
The assertions assume that `rst_n` is held low across at least one edge, and that inputs are stable around each edge. They also assume that `ptr_class` always carries one of the four defined codes, which the two-bit field guarantees. The stimulus keeps strobes to single frames separated by idle cycles. It holds the pointer class at a neutral normal value while the label and status runs are exercised, so that no two alarms change on the same edge unintentionally. The saturation sweep drives more than enough maximum-weight frames to reach the ceiling.

// File: rtl/pam_pkg.sv
package pam_pkg;
  typedef enum logic [1:0] {
    PTR_INVALID  = 2'd0,
    PTR_NORMAL   = 2'd1,
    PTR_NDF      = 2'd2,
    PTR_ALL_ONES = 2'd3
  } ptr_class_e;

  // Far-end error weight: 0..8 taken as is, anything larger is zero.
  function automatic logic [3:0] febe_weight(input logic [7:0] status);
    logic [3:0] field;
    field = status[7:4];
    return (field <= 4'd8) ? field : 4'd0;
  endfunction
endpackage

// File: rtl/pam_persist.sv
module pam_persist #(
  parameter int N = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic cond,
  output logic flag,
  output logic flip
);
  localparam int CW = $clog2(N + 1);
  logic [CW-1:0] run;

  always_comb flip = stb && (cond != flag) && (run == CW'(N - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run  <= '0;
      flag <= 1'b0;
    end else if (stb) begin
      if (cond == flag) begin
        run <= '0;
      end else if (flip) begin
        flag <= cond;
        run  <= '0;
      end else begin
        run <= run + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pam_ptr_mon.sv
module pam_ptr_mon
  import pam_pkg::*;
#(
  parameter int PTR_W  = 10,
  parameter int LOP_N  = 8,
  parameter int SYNC_N = 3,
  parameter int AIS_N  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  logic [1:0]       cls,
  input  logic [PTR_W-1:0] value,
  output logic             lop,
  output logic             ais,
  output logic             lop_set_ev,
  output logic             sync_ev,
  output logic             ais_set_ev,
  output logic             ais_ndf_ev
);
  localparam int LW = $clog2(LOP_N + 1);
  localparam int SW = $clog2(SYNC_N + 1);
  localparam int AW = $clog2(AIS_N + 1);

  logic [LW-1:0]    inv_run, ndf_run, inv_nxt, ndf_nxt;
  logic [SW-1:0]    same_run, same_nxt;
  logic [AW-1:0]    ais_run, ais_nxt;
  logic [PTR_W-1:0] last_val;

  always_comb begin
    inv_nxt  = '0;
    ndf_nxt  = '0;
    same_nxt = '0;
    ais_nxt  = '0;
    if (cls == PTR_INVALID)
      inv_nxt = (inv_run == LW'(LOP_N)) ? inv_run : inv_run + 1'b1;
    if (cls == PTR_NDF)
      ndf_nxt = (ndf_run == LW'(LOP_N)) ? ndf_run : ndf_run + 1'b1;
    if (cls == PTR_ALL_ONES)
      ais_nxt = (ais_run == AW'(AIS_N)) ? ais_run : ais_run + 1'b1;
    if (cls == PTR_NORMAL) begin
      if (same_run != '0 && value == last_val)
        same_nxt = (same_run == SW'(SYNC_N)) ? same_run : same_run + 1'b1;
      else
        same_nxt = SW'(1);
    end
  end

  assign lop_set_ev = stb && (inv_nxt == LW'(LOP_N) || ndf_nxt == LW'(LOP_N));
  assign sync_ev    = stb && (same_nxt == SW'(SYNC_N));
  assign ais_set_ev = stb && (ais_nxt == AW'(AIS_N));
  assign ais_ndf_ev = stb && (cls == PTR_NDF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inv_run  <= '0;
      ndf_run  <= '0;
      same_run <= '0;
      ais_run  <= '0;
      last_val <= '0;
      lop      <= 1'b0;
      ais      <= 1'b0;
    end else if (stb) begin
      inv_run  <= inv_nxt;
      ndf_run  <= ndf_nxt;
      same_run <= same_nxt;
      ais_run  <= ais_nxt;
      if (cls == PTR_NORMAL) last_val <= value;
      if (lop_set_ev)   lop <= 1'b1;
      else if (sync_ev) lop <= 1'b0;
      if (ais_set_ev)                  ais <= 1'b1;
      else if (sync_ev || ais_ndf_ev)  ais <= 1'b0;
    end
  end
endmodule

// File: rtl/pam_febe_acc.sv
module pam_febe_acc #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb,
  input  logic          clr,
  input  logic [3:0]    weight,
  output logic [CW-1:0] count,
  output logic          sat_hit
);
  logic [CW:0] sum;

  always_comb begin
    sum     = {1'b0, count} + (CW + 1)'(weight);
    sat_hit = stb && sum[CW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr)
      count <= '0;
    else if (stb)
      count <= sum[CW] ? {CW{1'b1}} : sum[CW-1:0];
  end
endmodule

// File: rtl/path_alarm_mon.sv
module path_alarm_mon
  import pam_pkg::*;
#(
  parameter int PTR_W     = 10,
  parameter int CNT_W     = 16,
  parameter int LOP_N     = 8,
  parameter int SYNC_N    = 3,
  parameter int AIS_N     = 3,
  parameter int C2_N      = 5,
  parameter int RDI_N     = 10,
  parameter logic [7:0] C2_EXPECT = 8'h13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_stb,
  input  logic [1:0]       ptr_class,
  input  logic [PTR_W-1:0] ptr_value,
  input  logic [7:0]       c2_byte,
  input  logic [7:0]       g1_byte,
  input  logic             cnt_clr,
  output logic             lop,
  output logic             path_ais,
  output logic             c2_mismatch,
  output logic             path_rdi,
  output logic [CNT_W-1:0] febe_count
);
  logic lop_set_ev, sync_ev, ais_set_ev, ais_ndf_ev;
  logic c2_flip, rdi_flip, sat_hit;
  logic c2_bad, rdi_bit;
  logic [3:0] weight;

  assign c2_bad  = (c2_byte != C2_EXPECT);
  assign rdi_bit = g1_byte[3];
  assign weight  = febe_weight(g1_byte);

  pam_ptr_mon #(.PTR_W(PTR_W), .LOP_N(LOP_N), .SYNC_N(SYNC_N), .AIS_N(AIS_N)) u_ptr (
    .clk(clk), .rst_n(rst_n), .stb(frame_stb), .cls(ptr_class), .value(ptr_value),
    .lop(lop), .ais(path_ais), .lop_set_ev(lop_set_ev), .sync_ev(sync_ev),
    .ais_set_ev(ais_set_ev), .ais_ndf_ev(ais_ndf_ev)
  );

  pam_persist #(.N(C2_N)) u_c2 (
    .clk(clk), .rst_n(rst_n), .stb(frame_stb), .cond(c2_bad),
    .flag(c2_mismatch), .flip(c2_flip)
  );

  pam_persist #(.N(RDI_N)) u_rdi (
    .clk(clk), .rst_n(rst_n), .stb(frame_stb), .cond(rdi_bit),
    .flag(path_rdi), .flip(rdi_flip)
  );

  pam_febe_acc #(.CW(CNT_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .stb(frame_stb), .clr(cnt_clr), .weight(weight),
    .count(febe_count), .sat_hit(sat_hit)
  );
endmodule

// File: rtl/path_alarm_mon_chk.sv
module path_alarm_mon_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_stb,
  input logic [1:0]       ptr_class,
  input logic             cnt_clr,
  input logic             lop,
  input logic             path_ais,
  input logic             c2_mismatch,
  input logic             path_rdi,
  input logic [CNT_W-1:0] febe_count,
  input logic             sync_ev,
  input logic             lop_set_ev
);
  assert_flags_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> $stable({lop, path_ais, c2_mismatch, path_rdi}));

  assert_lop_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lop) |-> $past(lop_set_ev));

  assert_lop_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lop) |-> $past(sync_ev));

  assert_ais_ndf_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && ptr_class == 2'd2) |=> !path_ais);

  assert_count_monotonic_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr |=> febe_count >= $past(febe_count));

  assert_count_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_clr && febe_count == {CNT_W{1'b1}}) |=> febe_count == {CNT_W{1'b1}});

  assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> febe_count == '0);
endmodule

bind path_alarm_mon path_alarm_mon_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .ptr_class(ptr_class),
  .cnt_clr(cnt_clr), .lop(lop), .path_ais(path_ais), .c2_mismatch(c2_mismatch),
  .path_rdi(path_rdi), .febe_count(febe_count), .sync_ev(sync_ev),
  .lop_set_ev(lop_set_ev)
);

// File: tb/sim_path_alarm_mon.sv
module sim_path_alarm_mon;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_stb = 1'b0;
  logic [1:0] ptr_class = 2'd1;
  logic [9:0] ptr_value = 10'd9;
  logic [7:0] c2_byte = 8'h13;
  logic [7:0] g1_byte = 8'h00;
  logic       cnt_clr = 1'b0;
  logic       lop, path_ais, c2_mismatch, path_rdi;
  logic [15:0] febe_count;

  int checks = 0;
  int errors = 0;
  int expect_cnt = 0;

  always #4 clk = ~clk;

  path_alarm_mon u0 (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .ptr_class(ptr_class),
    .ptr_value(ptr_value), .c2_byte(c2_byte), .g1_byte(g1_byte), .cnt_clr(cnt_clr),
    .lop(lop), .path_ais(path_ais), .c2_mismatch(c2_mismatch), .path_rdi(path_rdi),
    .febe_count(febe_count)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] c, input logic [9:0] v,
                      input logic [7:0] c2, input logic [7:0] g1);
    @(negedge clk);
    frame_stb = 1'b1; ptr_class = c; ptr_value = v; c2_byte = c2; g1_byte = g1;
    @(negedge clk);
    frame_stb = 1'b0; ptr_class = 2'd1; ptr_value = 10'd9; c2_byte = 8'h13; g1_byte = 8'h00;
  endtask

  function automatic int weight_of(input int nib);
    return (nib > 8) ? 0 : nib;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 lop", lop, 0); chk("R1 ais", path_ais, 0);
    chk("R1 c2", c2_mismatch, 0); chk("R1 rdi", path_rdi, 0);
    chk("R1 count", febe_count, 0);
    // R1 no strobe: inputs that would set alarms are ignored
    ptr_class = 2'd0; g1_byte = 8'h88; c2_byte = 8'h00;
    repeat (12) @(negedge clk);
    chk("R1 lop no strobe", lop, 0);
    chk("R1 c2 no strobe", c2_mismatch, 0);
    chk("R1 count no strobe", febe_count, 0);
    ptr_class = 2'd1; g1_byte = 8'h00; c2_byte = 8'h13;

    // R2 invalid-pointer run
    for (int i = 1; i <= 8; i++) begin
      send(2'd0, 10'd0, 8'h13, 8'h00);
      chk("R2 invalid run", lop, (i >= 8) ? 1 : 0);
    end
    // R3 three identical normal pointers
    for (int i = 1; i <= 3; i++) begin
      send(2'd1, 10'd50, 8'h13, 8'h00);
      chk("R3 identical run", lop, (i < 3) ? 1 : 0);
    end
    // R2 NDF-enabled run
    for (int i = 1; i <= 8; i++) begin
      send(2'd2, 10'd50, 8'h13, 8'h00);
      chk("R2 ndf run", lop, (i >= 8) ? 1 : 0);
    end
    // R3 value change restarts at one
    send(2'd1, 10'd5, 8'h13, 8'h00);
    send(2'd1, 10'd5, 8'h13, 8'h00);
    send(2'd1, 10'd6, 8'h13, 8'h00);
    chk("R3 restart after change", lop, 1);
    send(2'd1, 10'd6, 8'h13, 8'h00);
    chk("R3 second of new run", lop, 1);
    send(2'd1, 10'd6, 8'h13, 8'h00);
    chk("R3 third of new run", lop, 0);

    // R4 all-ones run
    for (int i = 1; i <= 3; i++) begin
      send(2'd3, 10'h3FF, 8'h13, 8'h00);
      chk("R4 ais run", path_ais, (i == 3) ? 1 : 0);
    end
    chk("R4 lop unaffected", lop, 0);
    // R5 single NDF-enabled pointer clears
    send(2'd2, 10'd7, 8'h13, 8'h00);
    chk("R5 ndf clear", path_ais, 0);
    // R5 identical run, broken by an invalid pointer
    for (int i = 1; i <= 3; i++) send(2'd3, 10'h3FF, 8'h13, 8'h00);
    chk("R4 ais again", path_ais, 1);
    send(2'd1, 10'd9, 8'h13, 8'h00);
    send(2'd1, 10'd9, 8'h13, 8'h00);
    send(2'd0, 10'd9, 8'h13, 8'h00);
    send(2'd1, 10'd9, 8'h13, 8'h00);
    send(2'd1, 10'd9, 8'h13, 8'h00);
    chk("R5 broken run holds", path_ais, 1);
    send(2'd1, 10'd9, 8'h13, 8'h00);
    chk("R5 identical clear", path_ais, 0);

    // R6 broken declare run
    for (int i = 1; i <= 4; i++) send(2'd1, 10'd9, 8'h00, 8'h00);
    send(2'd1, 10'd9, 8'h13, 8'h00);
    for (int i = 1; i <= 4; i++) send(2'd1, 10'd9, 8'h00, 8'h00);
    chk("R6 broken run", c2_mismatch, 0);
    send(2'd1, 10'd9, 8'h13, 8'h00);
    for (int i = 1; i <= 5; i++) begin
      send(2'd1, 10'd9, 8'h14, 8'h00);
      chk("R6 declare", c2_mismatch, (i == 5) ? 1 : 0);
    end
    for (int i = 1; i <= 4; i++) send(2'd1, 10'd9, 8'h13, 8'h00);
    send(2'd1, 10'd9, 8'hFF, 8'h00);
    for (int i = 1; i <= 5; i++) begin
      send(2'd1, 10'd9, 8'h13, 8'h00);
      chk("R6 clear", c2_mismatch, (i == 5) ? 0 : 1);
    end

    // R7 status bit run
    for (int i = 1; i <= 10; i++) begin
      send(2'd1, 10'd9, 8'h13, 8'h08);
      chk("R7 declare", path_rdi, (i == 10) ? 1 : 0);
    end
    for (int i = 1; i <= 10; i++) begin
      send(2'd1, 10'd9, 8'h13, 8'hF7);
      chk("R7 clear", path_rdi, (i == 10) ? 0 : 1);
    end
    chk("R8 count after rdi phase", febe_count, 0);

    // R10 plain clear, then R8 sweep of every nibble
    @(negedge clk); cnt_clr = 1'b1; @(negedge clk); cnt_clr = 1'b0;
    chk("R10 clear", febe_count, 0);
    expect_cnt = 0;
    for (int n = 0; n < 16; n++) begin
      send(2'd1, 10'd9, 8'h13, 8'(n << 4));
      expect_cnt += weight_of(n);
      chk("R8 nibble sweep", febe_count, expect_cnt);
    end

    // R9 saturation
    for (int i = 0; i < 8200; i++) send(2'd1, 10'd9, 8'h13, 8'h80);
    chk("R9 saturated", febe_count, 65535);
    send(2'd1, 10'd9, 8'h13, 8'h70);
    chk("R9 stays saturated", febe_count, 65535);

    // R10 clear coincident with a frame
    @(negedge clk);
    frame_stb = 1'b1; g1_byte = 8'h50; cnt_clr = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0; g1_byte = 8'h00; cnt_clr = 1'b0;
    chk("R10 clear wins", febe_count, 0);
    send(2'd1, 10'd9, 8'h13, 8'h30);
    chk("R10 count after clear", febe_count, 3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule